// File: doc/BRIEF.md
# Debug Entry Context Capture Unit

This unit sits beside a processor core. It snapshots the core's context at the moment the core stops and enters its background debug state. A one-bit strobe for each of three causes requests entry: a double bus fault, a software background instruction and a hardware breakpoint. On entry the unit does four things in the same clock edge. It encodes the winning cause, together with the core's 16-bit special status word, into a 32-bit entry status register. It copies the core's current instruction address into a return program counter. It freezes a fault address register that, while the core runs, follows the address of bus cycles. It raises a halted flag.

While the core is halted, the debug command path reads any of the three registers through a select code and may overwrite them. A resume request clears the halted flag and presents the return program counter as the address where prefetch restarts. If that address is odd, the unit pulses an address-error output.

Top module: `dbg_ctx_capture`

## Requirements
- R1: An entry whose winning cause is the double bus fault loads the entry status register with the special status word in bits 31:16 and 0xFFFF in bits 15:0.
- R2: An entry whose winning cause is the hardware breakpoint loads the entry status register with 0x00000000.
- R3: An entry whose winning cause is the background instruction loads the entry status register with 0x00000001.
- R4: When several cause strobes are high in the same cycle, the double bus fault wins over the breakpoint, and the breakpoint wins over the background instruction.
- R5: Any cause strobe that is high while the unit is not halted sets `halted` on the next clock edge and copies `cur_pc` into the return program counter at that edge. Cause strobes that arrive while the unit is halted change no register.
- R6: A double bus fault entry taken while `boot_fetch` is high loads the return program counter with 0xFFFFFFFF instead of `cur_pc`.
- R7: While the unit is not halted, every completed bus cycle (`bus_cyc`=1) loads `bus_addr` into the fault address register, whether `bus_err` is high or not. The value is held until a later bus cycle. While the unit is halted, bus cycles leave the register unchanged.
- R8: While halted, `dbg_wr` writes `dbg_wdata` into the register chosen by `dbg_sel`. The select codes are 0 for entry status, 1 for fault address and 2 for the return program counter. `dbg_rdata` always shows the selected register, and reads as zero for code 3.
- R9: A `dbg_wr` pulse while the unit is not halted has no effect on any register.
- R10: `resume_req` while halted clears `halted` on the next edge. `addr_err` is high for exactly the one cycle after that edge if bit 0 of the return program counter is 1, and is low otherwise. `resume_pc` always shows the return program counter.
- R11: An active-low reset clears all three registers, `halted` and `addr_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_dbf | input | 1 | Entry request, double bus fault cause |
| ent_bkpt | input | 1 | Entry request, hardware breakpoint cause |
| ent_swbg | input | 1 | Entry request, background instruction cause |
| ssw | input | 16 | Special status word from the core |
| cur_pc | input | 32 | Current instruction address |
| boot_fetch | input | 1 | Core is in its initial stack/PC fetch sequence |
| bus_cyc | input | 1 | A bus cycle completes this clock |
| bus_err | input | 1 | The completing bus cycle faulted |
| bus_addr | input | 32 | Address of the completing bus cycle |
| dbg_sel | input | 2 | Register select for debug access |
| dbg_wr | input | 1 | Debug write strobe |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Selected register contents |
| resume_req | input | 1 | Leave the debug state |
| halted | output | 1 | Core is in the debug state |
| resume_pc | output | 32 | Address where prefetch restarts |
| addr_err | output | 1 | Odd resume address, one-cycle pulse |

## Verification
A corrupted entry status or return address reaches `dbg_rdata` one cycle after the entry edge, so it shows up on the first read after halting. A wrong fault address shows up the same way, through a read that follows the faulting bus cycle by one clock. A stuck or spurious halted flag is visible directly on `halted`. A wrong odd/even judgement shows on `addr_err` in the single cycle after resume, so that cycle is sampled for every resume case, both odd and even. Priority errors appear only when causes collide, so the vector table includes every collision of two or three causes.

// File: rtl/dbg_ctx_pkg.sv
package dbg_ctx_pkg;

   typedef enum logic [1:0] {
      SEL_STATUS = 2'd0,
      SEL_FAR    = 2'd1,
      SEL_RPC    = 2'd2,
      SEL_NONE   = 2'd3
   } dbg_sel_e;

   typedef enum logic [1:0] {
      CAUSE_NONE = 2'd0,
      CAUSE_DBF  = 2'd1,
      CAUSE_BKPT = 2'd2,
      CAUSE_SWBG = 2'd3
   } cause_e;

endpackage

// File: rtl/dbg_cause_enc.sv
module dbg_cause_enc
   import dbg_ctx_pkg::*;
#(
   parameter int SW = 16
) (
   input  logic            dbf,
   input  logic            bkpt,
   input  logic            swbg,
   input  logic [SW-1:0]   ssw,
   output cause_e          cause,
   output logic [2*SW-1:0] code
);

   // fixed priority: double fault, then breakpoint, then software request
   always_comb begin
      if (dbf)       cause = CAUSE_DBF;
      else if (bkpt) cause = CAUSE_BKPT;
      else if (swbg) cause = CAUSE_SWBG;
      else           cause = CAUSE_NONE;
   end

   always_comb begin
      unique case (cause)
         CAUSE_DBF:  code = {ssw, {SW{1'b1}}};
         CAUSE_SWBG: code = {{SW{1'b0}}, SW'(1)};
         default:    code = '0;
      endcase
   end

endmodule

// File: rtl/dbg_far.sv
module dbg_far #(
   parameter int AW        = 32,
   parameter bit ANY_CYCLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          freeze,
   input  logic          bus_cyc,
   input  logic          bus_err,
   input  logic [AW-1:0] bus_addr,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_data,
   output logic [AW-1:0] far_q
);

   logic track;

   generate
      if (ANY_CYCLE) begin : g_any
         // every bus cycle overwrites; the last one before halting remains
         assign track = bus_cyc;
      end else begin : g_fault_only
         assign track = bus_cyc & bus_err;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                far_q <= '0;
      else if (freeze && wr_en)  far_q <= wr_data;
      else if (!freeze && track) far_q <= bus_addr;
   end

endmodule

// File: rtl/dbg_ctx_capture.sv
module dbg_ctx_capture
   import dbg_ctx_pkg::*;
#(
   parameter int AW            = 32,
   parameter int SW            = 16,
   parameter bit FAR_ANY_CYCLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ent_dbf,
   input  logic          ent_bkpt,
   input  logic          ent_swbg,
   input  logic [SW-1:0] ssw,
   input  logic [AW-1:0] cur_pc,
   input  logic          boot_fetch,
   input  logic          bus_cyc,
   input  logic          bus_err,
   input  logic [AW-1:0] bus_addr,
   input  logic [1:0]    dbg_sel,
   input  logic          dbg_wr,
   input  logic [AW-1:0] dbg_wdata,
   output logic [AW-1:0] dbg_rdata,
   input  logic          resume_req,
   output logic          halted,
   output logic [AW-1:0] resume_pc,
   output logic          addr_err
);

   localparam int STW = 2 * SW;

   if (AW < 2) begin : g_bad_aw
      $error("dbg_ctx_capture: AW must be at least 2");
   end
   if (SW < 2) begin : g_bad_sw
      $error("dbg_ctx_capture: SW must be at least 2");
   end
   if (STW > AW) begin : g_bad_stw
      $error("dbg_ctx_capture: status word must fit the data path");
   end

   cause_e           cause;
   logic [STW-1:0]   code;
   logic [STW-1:0]   status_q;
   logic [AW-1:0]    rpc_q;
   logic [AW-1:0]    far_q;
   logic             entry;
   logic             wr_status, wr_far, wr_rpc;

   dbg_cause_enc #(.SW(SW)) u_enc (
      .dbf   (ent_dbf),
      .bkpt  (ent_bkpt),
      .swbg  (ent_swbg),
      .ssw   (ssw),
      .cause (cause),
      .code  (code)
   );

   assign entry     = !halted && (cause != CAUSE_NONE);
   assign wr_status = halted && dbg_wr && (dbg_sel_e'(dbg_sel) == SEL_STATUS);
   assign wr_far    = halted && dbg_wr && (dbg_sel_e'(dbg_sel) == SEL_FAR);
   assign wr_rpc    = halted && dbg_wr && (dbg_sel_e'(dbg_sel) == SEL_RPC);

   dbg_far #(.AW(AW), .ANY_CYCLE(FAR_ANY_CYCLE)) u_far (
      .clk      (clk),
      .rst_n    (rst_n),
      .freeze   (halted),
      .bus_cyc  (bus_cyc),
      .bus_err  (bus_err),
      .bus_addr (bus_addr),
      .wr_en    (wr_far),
      .wr_data  (dbg_wdata),
      .far_q    (far_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halted   <= 1'b0;
         status_q <= '0;
         rpc_q    <= '0;
         addr_err <= 1'b0;
      end else begin
         addr_err <= 1'b0;
         if (entry) begin
            halted   <= 1'b1;
            status_q <= code;
            // a double fault during the boot fetch leaves an odd marker
            rpc_q    <= (cause == CAUSE_DBF && boot_fetch) ? {AW{1'b1}} : cur_pc;
         end else if (halted) begin
            if (wr_status) status_q <= dbg_wdata[STW-1:0];
            if (wr_rpc)    rpc_q    <= dbg_wdata;
            if (resume_req) begin
               halted   <= 1'b0;
               addr_err <= rpc_q[0];
            end
         end
      end
   end

   always_comb begin
      unique case (dbg_sel_e'(dbg_sel))
         SEL_STATUS: dbg_rdata = AW'(status_q);
         SEL_FAR:    dbg_rdata = far_q;
         SEL_RPC:    dbg_rdata = rpc_q;
         default:    dbg_rdata = '0;
      endcase
   end

   assign resume_pc = rpc_q;

endmodule

// File: rtl/dbg_ctx_capture_chk.sv
module dbg_ctx_capture_chk #(
   parameter int AW = 32,
   parameter int SW = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ent_dbf,
   input logic            ent_bkpt,
   input logic            ent_swbg,
   input logic [SW-1:0]   ssw,
   input logic            boot_fetch,
   input logic            dbg_wr,
   input logic            resume_req,
   input logic            halted,
   input logic            addr_err,
   input logic [2*SW-1:0] status_q,
   input logic [AW-1:0]   rpc_q,
   input logic [AW-1:0]   far_q
);

   logic any_req;
   assign any_req = ent_dbf | ent_bkpt | ent_swbg;

   // R1
   a_r1_dbf_status: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted && ent_dbf) |=> (halted && status_q == {$past(ssw), {SW{1'b1}}}));

   // R2 and R4
   a_r4_bkpt_beats_swbg: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted && !ent_dbf && ent_bkpt) |=> (halted && status_q == '0));

   // R3
   a_r3_swbg_status: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted && !ent_dbf && !ent_bkpt && ent_swbg) |=> (status_q == (2*SW)'(1)));

   // R6
   a_r6_boot_marker: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted && ent_dbf && boot_fetch) |=> (rpc_q == {AW{1'b1}}));

   // R5
   a_r5_hold_while_halted: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !dbg_wr && !resume_req) |=>
         (halted && $stable(status_q) && $stable(rpc_q) && $stable(far_q)));

   // R9
   a_r9_running_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted && !any_req) |=> ($stable(rpc_q) && $stable(status_q) && !halted));

   // R10
   a_r10_addr_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      addr_err |-> (!halted && rpc_q[0] && $past(halted) && $past(resume_req)));

   a_r10_addr_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      addr_err |=> !addr_err);

endmodule

bind dbg_ctx_capture dbg_ctx_capture_chk #(.AW(AW), .SW(SW)) u_chk (.*);

// File: tb/dbg_ctx_capture_bench.sv
module dbg_ctx_capture_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        ent_dbf, ent_bkpt, ent_swbg, boot_fetch;
   logic [15:0] ssw;
   logic [31:0] cur_pc, bus_addr, dbg_wdata, dbg_rdata, resume_pc;
   logic        bus_cyc, bus_err, dbg_wr, resume_req, halted, addr_err;
   logic [1:0]  dbg_sel;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   dbg_ctx_capture u_dbg_ctx_capture (.*);

   // vector: {dbf, bkpt, swbg, ssw[15:0], pc[31:0], expected status[31:0]}
   localparam int NV = 7;
   localparam logic [82:0] VEC [NV] = '{
      {3'b100, 16'hA5C3, 32'h0000_1000, 32'hA5C3_FFFF},
      {3'b010, 16'h7777, 32'h0000_2002, 32'h0000_0000},
      {3'b001, 16'h7777, 32'h0000_3004, 32'h0000_0001},
      {3'b110, 16'h1234, 32'h0040_0000, 32'h1234_FFFF},
      {3'b011, 16'h5555, 32'h0040_0010, 32'h0000_0000},
      {3'b101, 16'h0F0F, 32'h0040_0020, 32'h0F0F_FFFF},
      {3'b111, 16'hBEEF, 32'h8000_0002, 32'hBEEF_FFFF}
   };

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic rd(logic [1:0] sel, output logic [31:0] v);
      dbg_sel = sel;
      #1 v = dbg_rdata;
   endtask

   task automatic idle();
      ent_dbf = 0; ent_bkpt = 0; ent_swbg = 0; boot_fetch = 0;
      bus_cyc = 0; bus_err = 0; dbg_wr = 0; resume_req = 0;
   endtask

   task automatic do_resume();
      resume_req = 1'b1;
      tick();
      resume_req = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog got=%h exp=%h", 32'd0, 32'd1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v;
      idle();
      ssw = '0; cur_pc = '0; bus_addr = '0; dbg_wdata = '0; dbg_sel = '0;
      rst_n = 1'b0;
      tick(); tick();
      rst_n = 1'b1;

      // R11 reset state
      check("R11 halted", {31'd0, halted}, 32'd0);
      check("R11 addr_err", {31'd0, addr_err}, 32'd0);
      rd(2'd0, v); check("R11 status", v, 32'd0);
      rd(2'd1, v); check("R11 far", v, 32'd0);
      rd(2'd2, v); check("R11 rpc", v, 32'd0);

      // R1 R2 R3 R4 R5 R10: table walk
      for (int i = 0; i < NV; i++) begin
         ent_dbf  = VEC[i][82];
         ent_bkpt = VEC[i][81];
         ent_swbg = VEC[i][80];
         ssw      = VEC[i][79:64];
         cur_pc   = VEC[i][63:32];
         tick();
         idle();
         check("R5 halted", {31'd0, halted}, 32'd1);
         rd(2'd0, v); check("R1/R2/R3/R4 status", v, VEC[i][31:0]);
         rd(2'd2, v); check("R5 rpc", v, VEC[i][63:32]);
         check("R10 resume_pc", resume_pc, VEC[i][63:32]);
         do_resume();
         check("R10 halted cleared", {31'd0, halted}, 32'd0);
         check("R10 even no addr_err", {31'd0, addr_err}, 32'd0);
      end

      // R6 boot double fault gives odd marker, R10 odd resume
      ent_dbf = 1; boot_fetch = 1; cur_pc = 32'h0000_0400; ssw = 16'h00AA;
      tick(); idle();
      rd(2'd2, v); check("R6 rpc marker", v, 32'hFFFF_FFFF);
      do_resume();
      check("R10 odd addr_err", {31'd0, addr_err}, 32'd1);
      tick();
      check("R10 addr_err one cycle", {31'd0, addr_err}, 32'd0);

      // R6 boot_fetch with non-dbf cause keeps cur_pc
      ent_bkpt = 1; boot_fetch = 1; cur_pc = 32'h0000_0500;
      tick(); idle();
      rd(2'd2, v); check("R6 bkpt ignores boot", v, 32'h0000_0500);
      do_resume();

      // R7 FAR tracks bus cycles while running
      bus_cyc = 1; bus_addr = 32'h0000_0100; tick(); idle();
      rd(2'd1, v); check("R7 far load", v, 32'h0000_0100);
      bus_cyc = 1; bus_err = 1; bus_addr = 32'h0000_0204; tick(); idle();
      rd(2'd1, v); check("R7 far fault", v, 32'h0000_0204);
      tick();
      rd(2'd1, v); check("R7 far holds", v, 32'h0000_0204);
      bus_cyc = 1; bus_addr = 32'h0000_0308; tick(); idle();
      rd(2'd1, v); check("R7 far overwrite", v, 32'h0000_0308);
      // entry in the same cycle as a bus cycle: that cycle is the last one
      bus_cyc = 1; bus_err = 1; bus_addr = 32'h0000_040C; ent_dbf = 1; cur_pc = 32'h10;
      tick(); idle();
      bus_cyc = 1; bus_addr = 32'h0000_0999; tick(); idle();
      rd(2'd1, v); check("R7 far frozen halted", v, 32'h0000_040C);

      // R5 entries while halted ignored
      ent_swbg = 1; ent_bkpt = 1; cur_pc = 32'h0000_7770; ssw = 16'h1111;
      tick(); idle();
      rd(2'd0, v); check("R5 status kept", v, 32'h00AA_FFFF);
      rd(2'd2, v); check("R5 rpc kept", v, 32'h0000_0010);

      // R8 debug writes while halted
      dbg_wr = 1; dbg_sel = 2'd0; dbg_wdata = 32'hCAFE_0001; tick(); idle();
      dbg_wr = 1; dbg_sel = 2'd1; dbg_wdata = 32'h0000_ABC0; tick(); idle();
      dbg_wr = 1; dbg_sel = 2'd2; dbg_wdata = 32'h0000_2001; tick(); idle();
      dbg_wr = 1; dbg_sel = 2'd3; dbg_wdata = 32'hFFFF_FFFF; tick(); idle();
      rd(2'd0, v); check("R8 status write", v, 32'hCAFE_0001);
      rd(2'd1, v); check("R8 far write", v, 32'h0000_ABC0);
      rd(2'd2, v); check("R8 rpc write", v, 32'h0000_2001);
      rd(2'd3, v); check("R8 sel3 reads zero", v, 32'd0);
      do_resume();
      check("R10 odd write addr_err", {31'd0, addr_err}, 32'd1);

      // R9 writes while running ignored
      dbg_wr = 1; dbg_sel = 2'd2; dbg_wdata = 32'h0000_5550; tick(); idle();
      dbg_wr = 1; dbg_sel = 2'd0; dbg_wdata = 32'h0000_5551; tick(); idle();
      rd(2'd2, v); check("R9 rpc unchanged", v, 32'h0000_2001);
      rd(2'd0, v); check("R9 status unchanged", v, 32'hCAFE_0001);
      check("R9 still running", {31'd0, halted}, 32'd0);

      // R11 reset mid-halt clears everything
      ent_bkpt = 1; cur_pc = 32'h0000_0AA0; tick(); idle();
      rst_n = 1'b0; tick(); rst_n = 1'b1;
      check("R11 halted after reset", {31'd0, halted}, 32'd0);
      rd(2'd2, v); check("R11 rpc after reset", v, 32'd0);
      rd(2'd1, v); check("R11 far after reset", v, 32'd0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule